// File: doc/BRIEF.md
# E3 Transmit Overhead Inserter

This block produces the serial transmit bit stream of an E3 frame. Each frame is 1536 bit times long. It opens with a 12-bit overhead field: a 10-bit frame alignment word, then the alarm A-bit, then the national N-bit. The rest of the frame is payload, taken bit by bit from the serial data input. The block raises a payload-request strobe on every payload bit time, so an upstream source knows when to present its next bit. It raises an overhead indicator on every overhead bit time.

The N-bit has two sources. By default it comes from an internal data-link input. When the external select is high, it comes from a C-bit pin. That pin is captured on each rising edge of a C-bit strobe, and the strobe is sampled in the transmit clock domain. A packet data-link mode extends the overhead to 16 bits by appending the pattern 1,1,0,0. An external-overhead mode takes every overhead bit from the serial input instead of generating it.

A small state machine walks through the frame. The states are `ST_FAS` (alignment word), `ST_ABIT`, `ST_NBIT`, `ST_EXT` (4-bit extension) and `ST_PAY` (payload). The transitions are:
- `ST_FAS` to `ST_ABIT` on its tenth bit.
- `ST_ABIT` to `ST_NBIT`.
- `ST_NBIT` to `ST_EXT` if the extension mode is on, otherwise to `ST_PAY`.
- `ST_EXT` to `ST_PAY` on its fourth bit.
- `ST_PAY` to `ST_FAS` on the last bit of the frame.

Synchronous reset returns the machine to `ST_FAS` at bit position 0.

Top module: `e3_tx_ovh_inserter`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the block is at frame bit 0. At that point `ovh_o` is 1, `pay_req_o` is 0, and `tx_o` carries the first alignment bit, which is 1.
- R2: With `ext_ovh_i` low, frame bits 0 to 9 carry the alignment word 1111010000, leftmost bit first.
- R3: With `ext_ovh_i` low, frame bit 10 carries the value of `alarm_a_i`.
- R4: With `ext_ovh_i` and `ext_n_sel_i` low, frame bit 11 carries the value of `link_n_i`.
- R5: With `ext_n_sel_i` high, frame bit 11 carries the value that `cbit_i` had at the most recent clock edge where `cbit_clk_i` was seen going from 0 to 1. Changes of `cbit_i` without such an edge have no effect.
- R6: With the extension mode off, `ovh_o` is high for frame bits 0 to 11 and low for the rest of the frame.
- R7: When `pdl_en_i` is high at frame bit 11, frame bits 12 to 15 are overhead carrying 1,1,0,0 (unless R8 applies), and `ovh_o` stays high for bits 0 to 15. The value of `pdl_en_i` at any other bit time has no effect.
- R8: With `ext_ovh_i` high, every overhead bit time drives `tx_o` from `ser_i`.
- R9: `pay_req_o` is high exactly on the non-overhead bit times, and on those cycles `tx_o` equals `ser_i`.
- R10: Overhead restarts at bit 0 every 1536 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous reset, active high |
| alarm_a_i | input | 1 | Value sent as the A-bit |
| link_n_i | input | 1 | Internal data-link N-bit |
| ext_n_sel_i | input | 1 | 1: take the N-bit from the C-bit pin |
| cbit_clk_i | input | 1 | C-bit strobe; a rising edge captures `cbit_i` |
| cbit_i | input | 1 | External C-bit data pin |
| pdl_en_i | input | 1 | 1: append the 1100 extension to the overhead |
| ext_ovh_i | input | 1 | 1: take all overhead bits from `ser_i` |
| ser_i | input | 1 | Serial payload and external-overhead data |
| tx_o | output | 1 | Transmit bit stream |
| ovh_o | output | 1 | High during overhead bit times |
| pay_req_o | output | 1 | High on payload bit times; `ser_i` is consumed |

## Verification
The assertions count frame position from reset themselves, so they take the frame as starting with the first cycle after reset. They also assume that `ext_ovh_i`, `ext_n_sel_i`, `alarm_a_i` and `link_n_i` are stable while they are in use. The stimulus changes these configuration inputs only at frame bit 0. The one exception is `pdl_en_i`, which it deliberately flips in mid-payload to show that only the bit-11 value matters. The C-bit strobe rises at frame bit 3 and is held high until bit 8. During that window `cbit_i` is inverted to prove that a level with no new edge is ignored. This keeps every capture clear of the N-bit cycle.

// File: rtl/e3ovh_pkg.sv
package e3ovh_pkg;

    typedef enum logic [2:0] {
        ST_FAS  = 3'd0,
        ST_ABIT = 3'd1,
        ST_NBIT = 3'd2,
        ST_EXT  = 3'd3,
        ST_PAY  = 3'd4
    } ovh_state_t;

    localparam int          FAS_LEN  = 10;
    localparam logic [9:0]  FAS_WORD = 10'b1111010000;
    localparam int          EXT_LEN  = 4;
    localparam logic [3:0]  EXT_WORD = 4'b1100;
    localparam int          BASE_OVH = FAS_LEN + 2;
    localparam int          FULL_OVH = BASE_OVH + EXT_LEN;

endpackage

// File: rtl/e3ovh_seq.sv
module e3ovh_seq
    import e3ovh_pkg::*;
#(
    parameter int FRAME_BITS = 1536,
    parameter int PW         = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pdl_en_i,
    output ovh_state_t    state_o,
    output logic [PW-1:0] pos_o
);

    localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BITS - 1);
    localparam logic [PW-1:0] FAS_END  = PW'(FAS_LEN - 1);
    localparam logic [PW-1:0] EXT_END  = PW'(FULL_OVH - 1);

    ovh_state_t    state_q, state_d;
    logic [PW-1:0] pos_q;

    // bit position counter
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (pos_q == LAST_POS) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FAS;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FAS:  if (pos_q == FAS_END) state_d = ST_ABIT;
            ST_ABIT: state_d = ST_NBIT;
            ST_NBIT: state_d = pdl_en_i ? ST_EXT : ST_PAY;
            ST_EXT:  if (pos_q == EXT_END) state_d = ST_PAY;
            ST_PAY:  if (pos_q == LAST_POS) state_d = ST_FAS;
            default: state_d = ST_FAS;
        endcase
    end

    assign state_o = state_q;
    assign pos_o   = pos_q;

endmodule

// File: rtl/e3ovh_cbit_cap.sv
module e3ovh_cbit_cap (
    input  logic clk,
    input  logic rst,
    input  logic cbit_clk_i,
    input  logic cbit_i,
    output logic nbit_ext_o
);

    logic strobe_q;
    logic held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            held_q   <= 1'b0;
        end else begin
            strobe_q <= cbit_clk_i;
            if (cbit_clk_i && !strobe_q) begin
                held_q <= cbit_i;
            end
        end
    end

    assign nbit_ext_o = held_q;

endmodule

// File: rtl/e3ovh_bitsel.sv
module e3ovh_bitsel
    import e3ovh_pkg::*;
#(
    parameter int PW = 11
) (
    input  ovh_state_t    state_i,
    input  logic [PW-1:0] pos_i,
    input  logic          alarm_a_i,
    input  logic          link_n_i,
    input  logic          ext_n_sel_i,
    input  logic          nbit_ext_i,
    input  logic          ext_ovh_i,
    input  logic          ser_i,
    output logic          tx_o,
    output logic          ovh_o,
    output logic          pay_req_o
);

    logic [3:0]    fas_idx;
    logic [PW-1:0] ext_off;
    logic [1:0]    ext_idx;
    logic          gen_bit;

    assign fas_idx = 4'(FAS_LEN - 1) - pos_i[3:0];
    assign ext_off = pos_i - PW'(BASE_OVH);
    assign ext_idx = 2'(EXT_LEN - 1) - ext_off[1:0];

    // outputs
    always_comb begin
        gen_bit   = 1'b0;
        ovh_o     = 1'b1;
        pay_req_o = 1'b0;
        unique case (state_i)
            ST_FAS:  gen_bit = FAS_WORD[fas_idx];
            ST_ABIT: gen_bit = alarm_a_i;
            ST_NBIT: gen_bit = ext_n_sel_i ? nbit_ext_i : link_n_i;
            ST_EXT:  gen_bit = EXT_WORD[ext_idx];
            ST_PAY: begin
                ovh_o     = 1'b0;
                pay_req_o = 1'b1;
            end
            default: gen_bit = 1'b0;
        endcase
        tx_o = (ovh_o && !ext_ovh_i) ? gen_bit : ser_i;
    end

endmodule

// File: rtl/e3_tx_ovh_inserter.sv
module e3_tx_ovh_inserter
    import e3ovh_pkg::*;
#(
    parameter int FRAME_BITS = 1536
) (
    input  logic clk,
    input  logic rst,
    input  logic alarm_a_i,
    input  logic link_n_i,
    input  logic ext_n_sel_i,
    input  logic cbit_clk_i,
    input  logic cbit_i,
    input  logic pdl_en_i,
    input  logic ext_ovh_i,
    input  logic ser_i,
    output logic tx_o,
    output logic ovh_o,
    output logic pay_req_o
);

    localparam int PW = $clog2(FRAME_BITS);

    ovh_state_t    state;
    logic [PW-1:0] pos;
    logic          nbit_ext;

    e3ovh_seq #(.FRAME_BITS(FRAME_BITS), .PW(PW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .pdl_en_i (pdl_en_i),
        .state_o  (state),
        .pos_o    (pos)
    );

    e3ovh_cbit_cap u_cap (
        .clk        (clk),
        .rst        (rst),
        .cbit_clk_i (cbit_clk_i),
        .cbit_i     (cbit_i),
        .nbit_ext_o (nbit_ext)
    );

    e3ovh_bitsel #(.PW(PW)) u_sel (
        .state_i     (state),
        .pos_i       (pos),
        .alarm_a_i   (alarm_a_i),
        .link_n_i    (link_n_i),
        .ext_n_sel_i (ext_n_sel_i),
        .nbit_ext_i  (nbit_ext),
        .ext_ovh_i   (ext_ovh_i),
        .ser_i       (ser_i),
        .tx_o        (tx_o),
        .ovh_o       (ovh_o),
        .pay_req_o   (pay_req_o)
    );

endmodule

// File: rtl/e3ovh_chk.sv
module e3ovh_chk
    import e3ovh_pkg::*;
#(
    parameter int FRAME_BITS = 1536
) (
    input logic clk,
    input logic rst,
    input logic alarm_a_i,
    input logic link_n_i,
    input logic ext_n_sel_i,
    input logic ext_ovh_i,
    input logic ser_i,
    input logic tx_o,
    input logic ovh_o,
    input logic pay_req_o
);

    localparam int CW = $clog2(FRAME_BITS);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == CW'(FRAME_BITS - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    // R10
    frame_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |-> ovh_o);

    // R6
    base_ovh_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt < CW'(BASE_OVH)) |-> ovh_o);

    // R7
    ovh_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt >= CW'(FULL_OVH)) |-> !ovh_o);

    // R7
    ovh_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ovh_o) |-> (cnt == CW'(BASE_OVH) || cnt == CW'(FULL_OVH)));

    // R9
    payload_pass_chk: assert property (@(posedge clk) disable iff (rst)
        pay_req_o |-> (tx_o == ser_i && !ovh_o));

    // R8
    ext_ovh_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (ovh_o && ext_ovh_i) |-> (tx_o == ser_i));

    // R3
    abit_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(FAS_LEN) && !ext_ovh_i) |-> (tx_o == alarm_a_i));

    // R4
    nbit_int_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(FAS_LEN + 1) && !ext_ovh_i && !ext_n_sel_i) |-> (tx_o == link_n_i));

endmodule

bind e3_tx_ovh_inserter e3ovh_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .alarm_a_i   (alarm_a_i),
    .link_n_i    (link_n_i),
    .ext_n_sel_i (ext_n_sel_i),
    .ext_ovh_i   (ext_ovh_i),
    .ser_i       (ser_i),
    .tx_o        (tx_o),
    .ovh_o       (ovh_o),
    .pay_req_o   (pay_req_o)
);

// File: tb/test_e3_tx_ovh_inserter.sv
`timescale 1ns/1ps
module test_e3_tx_ovh_inserter;

    localparam int FRAME = 1536;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alarm_a_i = 1'b0, link_n_i = 1'b0, ext_n_sel_i = 1'b0;
    logic cbit_clk_i = 1'b0, cbit_i = 1'b0, pdl_en_i = 1'b0;
    logic ext_ovh_i = 1'b0, ser_i = 1'b0;
    logic tx_o, ovh_o, pay_req_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] lfsr = 16'hACE1;

    typedef struct {
        logic  tx;
        logic  ovh;
        logic  req;
        string tag;
        string otag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    e3_tx_ovh_inserter #(.FRAME_BITS(FRAME)) i_e3_tx_ovh_inserter (
        .clk(clk), .rst(rst), .alarm_a_i(alarm_a_i), .link_n_i(link_n_i),
        .ext_n_sel_i(ext_n_sel_i), .cbit_clk_i(cbit_clk_i), .cbit_i(cbit_i),
        .pdl_en_i(pdl_en_i), .ext_ovh_i(ext_ovh_i), .ser_i(ser_i),
        .tx_o(tx_o), .ovh_o(ovh_o), .pay_req_o(pay_req_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // monitor: pops one expected item per cycle
    always begin
        @(negedge clk);
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, tx_o, e.tx);
            check(e.otag, ovh_o, e.ovh);
            check("R9", pay_req_o, e.req);
        end
    end

    // driver: one frame with a fixed configuration
    task automatic run_frame(input int fidx, input logic alm, input logic lnk,
                             input logic sel, input logic cval, input logic pdl,
                             input logic eovh);
        localparam logic [9:0] FAS = 10'b1111010000;
        localparam logic [3:0] EXT = 4'b1100;
        for (int p = 0; p < FRAME; p++) begin
            exp_t e;
            int   olen;
            @(negedge clk);
            rst = 1'b0;
            if (p == 0) begin
                alarm_a_i = alm; link_n_i = lnk; ext_n_sel_i = sel;
                pdl_en_i = pdl; ext_ovh_i = eovh; cbit_i = ~cval;
            end
            if (p == 3) begin cbit_clk_i = 1'b1; cbit_i = cval; end
            if (p == 6) cbit_i = ~cval;        // R5: no edge, ignored
            if (p == 8) cbit_clk_i = 1'b0;
            if (p == 200) pdl_en_i = ~pdl;     // R7: ignored off bit 11
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ser_i = lfsr[0];
            olen = pdl ? 16 : 12;
            e.ovh  = (p < olen);
            e.req  = !e.ovh;
            e.otag = pdl ? "R7" : "R6";
            if (!e.ovh) begin
                e.tx = ser_i; e.tag = "R9";
            end else if (eovh) begin
                e.tx = ser_i; e.tag = "R8";
            end else if (p < 10) begin
                e.tx = FAS[9 - p]; e.tag = (p == 0) ? ((fidx == 0) ? "R1" : "R10") : "R2";
            end else if (p == 10) begin
                e.tx = alm; e.tag = "R3";
            end else if (p == 11) begin
                e.tx = sel ? cval : lnk; e.tag = sel ? "R5" : "R4";
            end else begin
                e.tx = EXT[15 - p]; e.tag = "R7";
            end
            if (p == 0 && e.ovh !== 1'b1) e.otag = "R10";
            sb.push_back(e);
        end
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1: reset state
        check("R1", ovh_o, 1'b1);
        check("R1", pay_req_o, 1'b0);
        check("R1", tx_o, 1'b1);
        run_frame(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame(1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        run_frame(2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        run_frame(3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        run_frame(4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        run_frame(5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule